// File: doc/BRIEF.md
# Endpoint 0 Setup Capture and OUT Handshake Unit

This unit handles the endpoint 0 side of control write transfers whose requests are decoded in software. A link layer upstream delivers already-decoded packets as a start strobe, a byte stream and an end strobe carrying a good/bad status. The unit collects the 8-byte payload of a SETUP transaction into a private setup buffer. It acknowledges the transaction, raises a setup flag and asserts the interrupt line.

Software claims the setup buffer by raising a select level. That rising edge clears the setup flag. Software then pulls the eight bytes one by one through a single read-data port and drops the select. If the setup flag is set again once reading is done, a newer SETUP overwrote the buffer during the read, and software must read it again.

For OUT transactions of the data stage, the handshake comes from two software-controlled bits: a stall bit and a receive-enable bit. Accepted bytes are committed to a receive FIFO, an OUT flag is raised, and the enable bit drops so that software must re-arm it for every packet.

Top module: `ep0_setup_ctrl`

## Requirements
- R1: After reset, flag_setup, flag_out, irq, fifo_en, ep0_stall and hs_valid are 0 and rx_level is 0.
- R2: A SETUP packet (lnk_setup=1 at lnk_start) that ends with lnk_good=1 after exactly 8 bytes is answered on the cycle after lnk_end with hs_valid=1 and hs_code=2'b01 (ACK), whatever the stall and enable bits are. The bytes are stored, and flag_setup and irq become 1.
- R3: A SETUP packet that ends with lnk_good=0, or with a byte count other than 8, gets no handshake and leaves the setup buffer and flag_setup unchanged.
- R4: A rising edge of cpu_setup_sel clears flag_setup and rewinds the setup read position to byte 0. If a SETUP is stored in the same cycle, flag_setup ends up 1.
- R5: While cpu_setup_sel is 1, cpu_rdata shows the setup byte at the read position, and each cycle with cpu_rd=1 advances that position by one, in arrival order.
- R6: A stored SETUP overwrites the buffer, rewinds the read position to 0 even in the middle of a read, sets flag_setup, and clears ep0_stall.
- R7: A good OUT packet is answered on the cycle after lnk_end with STALL (2'b11) if ep0_stall is 1. Otherwise it is answered with NAK (2'b10) if fifo_en was 0 at lnk_start, and with ACK (2'b01) if not. An OUT packet ending with lnk_good=0 gets no handshake.
- R8: On an OUT ACK, the packet's bytes are added to the receive FIFO (rx_level grows by the byte count, zero included), flag_out and irq become 1, and fifo_en returns to 0.
- R9: An OUT packet answered with NAK or STALL, or given no handshake, adds nothing to the receive FIFO.
- R10: An enabled OUT packet with more bytes than the free FIFO space is answered with NAK and stores nothing. A packet that exactly fills the FIFO is ACKed.
- R11: While cpu_setup_sel is 0, cpu_rd pops the receive FIFO in arrival order, with cpu_rdata showing the head byte. cpu_out_clr clears flag_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lnk_start | input | 1 | Packet start strobe |
| lnk_setup | input | 1 | With lnk_start: 1 for SETUP, 0 for OUT |
| lnk_dv | input | 1 | Data byte valid (never in the lnk_end cycle) |
| lnk_data | input | DW | Data byte |
| lnk_end | input | 1 | Packet end strobe |
| lnk_good | input | 1 | With lnk_end: packet free of errors, correct data PID |
| hs_valid | output | 1 | One-cycle handshake strobe |
| hs_code | output | 2 | 01 ACK, 10 NAK, 11 STALL |
| cpu_setup_sel | input | 1 | Setup buffer select level |
| cpu_rd | input | 1 | Read strobe for the data port |
| cpu_rdata | output | DW | Read data port |
| cpu_fifo_en_set | input | 1 | Arm reception of one OUT packet |
| cpu_stall_set | input | 1 | Set the endpoint 0 stall bit |
| cpu_stall_clr | input | 1 | Clear the endpoint 0 stall bit |
| cpu_out_clr | input | 1 | Clear the OUT flag |
| fifo_en | output | 1 | Receive-enable bit |
| ep0_stall | output | 1 | Stall bit |
| flag_setup | output | 1 | Setup flag |
| flag_out | output | 1 | OUT-received flag |
| irq | output | 1 | Interrupt, either flag set |
| rx_level | output | $clog2(RX_DEPTH)+1 | Committed bytes in the receive FIFO |

## Verification
Almost every internal slip appears at the ports within one cycle of the event that caused it. A wrong acceptance latch or a stale stall bit gives the wrong hs_code on the cycle after lnk_end. A bad commit of the speculative write count changes rx_level at that same edge. A setup read position that fails to rewind shows up on the very next cpu_rdata sample. A staging buffer corrupted by a rejected packet stays hidden until the buffer is read, so each rejected SETUP is followed by a read of the buffer.

// File: rtl/ep0_setup_ctrl.sv
module ep0_setup_ctrl #(
  parameter int RX_DEPTH = 16,
  parameter int DW       = 8,
  localparam int AW      = $clog2(RX_DEPTH),
  localparam int CW      = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lnk_start,
  input  logic          lnk_setup,
  input  logic          lnk_dv,
  input  logic [DW-1:0] lnk_data,
  input  logic          lnk_end,
  input  logic          lnk_good,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  input  logic          cpu_setup_sel,
  input  logic          cpu_rd,
  output logic [DW-1:0] cpu_rdata,
  input  logic          cpu_fifo_en_set,
  input  logic          cpu_stall_set,
  input  logic          cpu_stall_clr,
  input  logic          cpu_out_clr,
  output logic          fifo_en,
  output logic          ep0_stall,
  output logic          flag_setup,
  output logic          flag_out,
  output logic          irq,
  output logic [CW-1:0] rx_level
);
  localparam int SLEN = 8;
  localparam logic [1:0] HS_ACK = 2'b01, HS_NAK = 2'b10, HS_STALL = 2'b11;

  logic [DW-1:0] setup_buf [SLEN];
  logic [DW-1:0] stage     [SLEN];
  logic [DW-1:0] mem       [RX_DEPTH];
  logic [3:0]    stg_cnt;
  logic [2:0]    sptr;
  logic          sel_q, in_pkt, pkt_setup, pkt_acc, ovf;
  logic [CW-1:0] spec_cnt, wr_ptr, rd_ptr;

  logic          sel_rise, end_ok, setup_commit, out_end, out_ack, room, pop;
  logic [CW:0]   used;
  logic [AW-1:0] wr_idx;

  assign sel_rise     = cpu_setup_sel & ~sel_q;
  assign end_ok       = lnk_end & in_pkt & lnk_good;
  assign setup_commit = end_ok & pkt_setup & (stg_cnt == 4'd8);
  assign out_end      = end_ok & ~pkt_setup;
  assign out_ack      = out_end & ~ep0_stall & pkt_acc & ~ovf;
  assign rx_level     = wr_ptr - rd_ptr;
  assign used         = {1'b0, rx_level} + {1'b0, spec_cnt};
  assign room         = used < (CW+1)'(RX_DEPTH);
  assign wr_idx       = wr_ptr[AW-1:0] + spec_cnt[AW-1:0];
  assign pop          = cpu_rd & ~cpu_setup_sel & (rx_level != '0);
  assign cpu_rdata    = cpu_setup_sel ? setup_buf[sptr] : mem[rd_ptr[AW-1:0]];
  assign irq          = flag_setup | flag_out;

  always_ff @(posedge clk) begin
    if (lnk_dv && in_pkt && pkt_setup && stg_cnt < 4'd8) stage[stg_cnt[2:0]] <= lnk_data;
    if (lnk_dv && in_pkt && !pkt_setup && pkt_acc && room) mem[wr_idx] <= lnk_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLEN; i++) setup_buf[i] <= '0;
    end else if (setup_commit) begin
      for (int i = 0; i < SLEN; i++) setup_buf[i] <= stage[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt <= 1'b0; pkt_setup <= 1'b0; pkt_acc <= 1'b0; ovf <= 1'b0;
      stg_cnt <= '0; spec_cnt <= '0;
    end else if (lnk_start) begin
      in_pkt <= 1'b1; pkt_setup <= lnk_setup; pkt_acc <= fifo_en & ~ep0_stall;
      ovf <= 1'b0; stg_cnt <= '0; spec_cnt <= '0;
    end else if (lnk_end) begin
      in_pkt <= 1'b0;
    end else if (lnk_dv && in_pkt) begin
      if (pkt_setup) begin
        if (stg_cnt != 4'hF) stg_cnt <= stg_cnt + 4'd1;
      end else if (pkt_acc) begin
        if (room) spec_cnt <= spec_cnt + 1'b1;
        else      ovf <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0;
    end else begin
      if (out_ack) wr_ptr <= wr_ptr + spec_cnt;
      if (pop)     rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid <= 1'b0; hs_code <= 2'b00;
    end else begin
      hs_valid <= setup_commit | out_end;
      if (setup_commit || out_ack) hs_code <= HS_ACK;
      else if (out_end)            hs_code <= ep0_stall ? HS_STALL : HS_NAK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0; sptr <= '0; flag_setup <= 1'b0; flag_out <= 1'b0;
      fifo_en <= 1'b0; ep0_stall <= 1'b0;
    end else begin
      sel_q <= cpu_setup_sel;

      if (setup_commit || sel_rise)  sptr <= '0;
      else if (cpu_rd && cpu_setup_sel) sptr <= sptr + 3'd1;

      if (setup_commit)  flag_setup <= 1'b1;
      else if (sel_rise) flag_setup <= 1'b0;

      if (out_ack)          flag_out <= 1'b1;
      else if (cpu_out_clr) flag_out <= 1'b0;

      if (out_ack)              fifo_en <= 1'b0;
      else if (cpu_fifo_en_set) fifo_en <= 1'b1;

      if (setup_commit)       ep0_stall <= 1'b0;
      else if (cpu_stall_set) ep0_stall <= 1'b1;
      else if (cpu_stall_clr) ep0_stall <= 1'b0;
    end
  end
endmodule

// File: rtl/ep0_setup_ctrl_chk.sv
module ep0_setup_ctrl_chk #(
  parameter int RX_DEPTH = 16,
  localparam int CW      = $clog2(RX_DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hs_valid,
  input logic [1:0]    hs_code,
  input logic          fifo_en,
  input logic          ep0_stall,
  input logic          flag_setup,
  input logic          flag_out,
  input logic [CW-1:0] rx_level
);
  AST_SETUP_FLAG_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_setup) |-> (hs_valid && hs_code == 2'b01)); // R2
  AST_SETUP_CLEARS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_setup) |-> !ep0_stall); // R6
  AST_NAK_NOT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'b10) |-> !$past(ep0_stall)); // R7
  AST_STALL_FROM_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'b11) |-> $past(ep0_stall)); // R7
  AST_ENABLE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_out) |-> !fifo_en); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= CW'(RX_DEPTH)); // R10
endmodule

bind ep0_setup_ctrl ep0_setup_ctrl_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs_valid(hs_valid), .hs_code(hs_code),
  .fifo_en(fifo_en), .ep0_stall(ep0_stall), .flag_setup(flag_setup),
  .flag_out(flag_out), .rx_level(rx_level)
);

// File: tb/ep0_setup_ctrl_tb.sv
module ep0_setup_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic lnk_start = 0, lnk_setup = 0, lnk_dv = 0, lnk_end = 0, lnk_good = 0;
  logic [7:0] lnk_data = '0;
  logic cpu_setup_sel = 0, cpu_rd = 0, cpu_fifo_en_set = 0;
  logic cpu_stall_set = 0, cpu_stall_clr = 0, cpu_out_clr = 0;
  logic hs_valid, fifo_en, ep0_stall, flag_setup, flag_out, irq;
  logic [1:0] hs_code;
  logic [7:0] cpu_rdata;
  logic [CW-1:0] rx_level;

  ep0_setup_ctrl #(.RX_DEPTH(DEPTH), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .lnk_start(lnk_start), .lnk_setup(lnk_setup),
    .lnk_dv(lnk_dv), .lnk_data(lnk_data), .lnk_end(lnk_end), .lnk_good(lnk_good),
    .hs_valid(hs_valid), .hs_code(hs_code), .cpu_setup_sel(cpu_setup_sel),
    .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .cpu_fifo_en_set(cpu_fifo_en_set),
    .cpu_stall_set(cpu_stall_set), .cpu_stall_clr(cpu_stall_clr),
    .cpu_out_clr(cpu_out_clr), .fifo_en(fifo_en), .ep0_stall(ep0_stall),
    .flag_setup(flag_setup), .flag_out(flag_out), .irq(irq), .rx_level(rx_level)
  );

  // {stall_set, en_set, good, nbytes[3:0], exp_valid, exp_code[1:0]}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b1, 4'd4, 1'b1, 2'b10},
    {1'b0, 1'b1, 1'b1, 4'd4, 1'b1, 2'b01},
    {1'b1, 1'b1, 1'b1, 4'd4, 1'b1, 2'b11},
    {1'b0, 1'b0, 1'b1, 4'd0, 1'b1, 2'b01},
    {1'b0, 1'b1, 1'b0, 4'd3, 1'b0, 2'b00},
    {1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 2'b01},
    {1'b1, 1'b0, 1'b1, 4'd2, 1'b1, 2'b11},
    {1'b0, 1'b0, 1'b1, 4'd5, 1'b1, 2'b10}
  };

  int n_tests = 0, n_fail = 0;
  logic [7:0] pkt [32];
  logic got_v;
  logic [1:0] got_c;
  logic [7:0] rv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input bit is_setup, input int n, input bit good, input bit sel_at_end);
    lnk_start = 1; lnk_setup = is_setup;
    @(negedge clk) lnk_start = 0;
    for (int k = 0; k < n; k++) begin
      lnk_dv = 1; lnk_data = pkt[k];
      @(negedge clk);
    end
    lnk_dv = 0; lnk_end = 1; lnk_good = good;
    if (sel_at_end) cpu_setup_sel = 1;
    @(negedge clk) lnk_end = 0;
    got_v = hs_valid; got_c = hs_code;
  endtask

  task automatic rd(output logic [7:0] v);
    v = cpu_rdata; cpu_rd = 1;
    @(negedge clk) cpu_rd = 0;
  endtask

  task automatic fill(input logic [7:0] base, input int n);
    for (int k = 0; k < n; k++) pkt[k] = base + 8'(k);
  endtask

  task automatic pulse_en();    cpu_fifo_en_set = 1; @(negedge clk) cpu_fifo_en_set = 0; endtask
  task automatic pulse_stall(); cpu_stall_set = 1;   @(negedge clk) cpu_stall_set = 0;   endtask
  task automatic pulse_unst();  cpu_stall_clr = 1;   @(negedge clk) cpu_stall_clr = 0;   endtask
  task automatic pulse_oclr();  cpu_out_clr = 1;     @(negedge clk) cpu_out_clr = 0;     endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags", {flag_setup, flag_out, irq}, 3'b000);
    chk("R1 ctrl", {fifo_en, ep0_stall, hs_valid}, 3'b000);
    chk("R1 level", rx_level, 0);

    // Setup accepted regardless of stall; stall cleared
    pulse_stall();
    fill(8'hA0, 8);
    send(1, 8, 1, 0);
    chk("R2 hs", {got_v, got_c}, 3'b101);
    chk("R2 flag/irq", {flag_setup, irq}, 2'b11);
    chk("R6 stall cleared", ep0_stall, 0);

    cpu_setup_sel = 1; @(negedge clk);
    chk("R4 flag cleared", flag_setup, 0);
    for (int k = 0; k < 8; k++) begin rd(rv); chk("R5 setup byte", rv, 8'hA0 + 8'(k)); end
    cpu_setup_sel = 0; @(negedge clk);

    // Rejected setups
    fill(8'hB0, 8);
    send(1, 8, 0, 0);
    chk("R3 bad no hs", got_v, 0);
    send(1, 7, 1, 0);
    chk("R3 short no hs", got_v, 0);
    send(1, 9, 1, 0);
    chk("R3 long no hs", got_v, 0);
    chk("R3 flag kept", flag_setup, 0);
    cpu_setup_sel = 1; @(negedge clk);
    rd(rv); chk("R3 buffer kept b0", rv, 8'hA0);
    rd(rv); rd(rv); chk("R5 third byte", rv, 8'hA2);

    // New setup mid-read
    fill(8'hC0, 8);
    send(1, 8, 1, 0);
    chk("R6 hs", {got_v, got_c}, 3'b101);
    chk("R6 flag set mid-read", flag_setup, 1);
    for (int k = 0; k < 8; k++) begin rd(rv); chk("R6 rewound byte", rv, 8'hC0 + 8'(k)); end
    cpu_setup_sel = 0; @(negedge clk);
    cpu_setup_sel = 1; @(negedge clk);
    chk("R4 reselect clears", flag_setup, 0);
    cpu_setup_sel = 0; @(negedge clk);

    // Select rising in the same cycle a setup is stored
    fill(8'hD0, 8);
    send(1, 8, 1, 1);
    chk("R4 commit wins", flag_setup, 1);
    rd(rv); chk("R4 new byte0", rv, 8'hD0);
    cpu_setup_sel = 0; @(negedge clk);
    cpu_setup_sel = 1; @(negedge clk);
    cpu_setup_sel = 0; @(negedge clk);

    // OUT handshake table
    for (int i = 0; i < 8; i++) begin
      int n;
      n = int'(VEC[i][6:3]);
      if (VEC[i][9]) pulse_stall();
      if (VEC[i][8]) pulse_en();
      fill(8'(16 * i), n);
      send(0, n, VEC[i][7], 0);
      chk("R7 hs valid", got_v, VEC[i][2]);
      if (VEC[i][2]) chk("R7 hs code", got_c, VEC[i][1:0]);
      if (VEC[i][2] && VEC[i][1:0] == 2'b01) begin
        chk("R8 flag/irq", {flag_out, irq}, 2'b11);
        chk("R8 enable cleared", fifo_en, 0);
        chk("R8 level", rx_level, n);
        for (int k = 0; k < n; k++) begin rd(rv); chk("R11 pop order", rv, 8'(16 * i + k)); end
        chk("R11 drained", rx_level, 0);
        pulse_oclr();
        chk("R11 out flag clr", flag_out, 0);
      end else begin
        chk("R9 nothing stored", rx_level, 0);
      end
      pulse_unst();
    end

    // Overflow and exact fill
    pulse_en();
    fill(8'h50, 17);
    send(0, 17, 1, 0);
    chk("R10 overflow nak", {got_v, got_c}, 3'b110);
    chk("R10 nothing stored", rx_level, 0);
    send(0, 16, 1, 0);
    chk("R10 exact fill ack", {got_v, got_c}, 3'b101);
    chk("R10 full level", rx_level, 16);
    for (int k = 0; k < 16; k++) begin rd(rv); chk("R11 full pop", rv, 8'h50 + 8'(k)); end
    chk("R11 empty", rx_level, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule